// File: doc/BRIEF.md
# Framed byte-serial link transmitter

This block sends read and write transactions over a byte-wide serial link with a frame strobe. It runs in two clock domains. The core clock runs at one quarter of the serial clock and is derived in phase with it. Every decision is made in the core domain: which transaction goes next, whether a burst continues, which word goes on the line, and the done and count bookkeeping. The serial domain takes one prepared 32-bit word per core cycle, sends it as four bytes (most significant byte first), and drives the frame with it.

A packet is a header word, then an address word, then a data word. The header's top byte holds the command bits: bit 0 marks a write, bit 1 marks a burst, and bit 2 selects streaming to one address. The next byte holds the control field and the rest is zero. A burst-marked write may be followed, with the frame held high, by one extra data word for each further write. In incrementing mode each of those writes goes to the previous address plus the step. In streaming mode each goes to the same address.

The receiver's wait input is asynchronous. It is synchronised once, in the serial domain, and is examined at each word boundary. A stalled word is not sent and the frame drops. Any packet cut short by a stall is sent again from its header once wait clears. Upstream sources use valid/ready: a transaction transfers on a core edge where both are high. The source must hold the transaction stable while ready is low, and ready stays low for as long as a stall is pending.

Top module: `lnk_tx`

## Requirements
- R1: After reset the frame is low, the serial data is zero, done is high and the packet counter is zero. Whenever the frame is low the serial data is zero.
- R2: A packet that does not continue a burst is sent as header, address and data words, MSB byte first, with the frame high for exactly 12 serial cycles. The header top byte is {5'b0, stream, burst, write} and the next byte is the control field. Between two separate packets the frame is low for at least 4 serial cycles.
- R3: A transaction transfers on a core edge where in_valid and in_ready are both high. in_ready is low while a wait stall is pending.
- R4: A write with the burst request set marks its header burst bit. A following write counts as a continuation when it also requests a burst, has the same control and stream flags, and its address is the previous address plus ADDR_STEP. A continuation is sent as a single data word, with the frame held high from the previous word.
- R5: With the stream flag set on a burst write, header bit 2 is set, and continuations go to the same address as the previous write.
- R6: A write that does not qualify as a continuation ends the burst. The frame drops and the write starts a new packet with its own header.
- R7: A wait input that rises during transmission drives the frame low within 6 serial cycles. The frame stays low while wait is held.
- R8: Every accepted transaction is delivered exactly once, in order, across stalls. A packet cut short by a stall is sent again from its header.
- R9: done goes low while a burst-marked packet is on the link and returns high once the link is idle.
- R10: The packet counter, CNT_W bits wide, increments by one per delivered transaction and wraps modulo 2^CNT_W.
- R11: The frame changes only on 4-byte word boundaries, so every frame-high run is a whole number of words.
- R12: A read never carries the burst or stream bits, even if the burst request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial byte clock |
| clk_core | input | 1 | Core clock, serial clock divided by 4, in phase |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| in_valid | input | 1 | Upstream transaction valid |
| in_ready | output | 1 | Transmitter can take a transaction |
| in_addr | input | 32 | Transaction address |
| in_data | input | 32 | Transaction data |
| in_ctrl | input | CTRL_W | Control field carried in the header |
| in_write | input | 1 | 1 = write, 0 = read |
| in_burst | input | 1 | Request burst framing for writes |
| in_stream | input | 1 | Burst writes go to one address |
| link_wait | input | 1 | Asynchronous backpressure from the receiver |
| ser_data | output | 8 | Serial byte |
| ser_frame | output | 1 | Frame strobe |
| done | output | 1 | Link is idle and no burst is in progress |
| pkt_count | output | CNT_W | Delivered transaction counter |

## Verification
The bench builds the block with CNT_W set to 5. A single 40-write burst therefore takes the counter past its wrap point, and the same long run also shows that the core path can accept one transaction every core cycle without a break in the frame. ADDR_STEP stays at 8 and the sync depth stays at 2, which makes the six-cycle halt bound exact. A bench-side decoder rebuilds the transactions from the serial bytes alone. A stall is forced in the middle of a burst to show that nothing is lost or repeated across it.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {W_IDLE, W_HEAD, W_ADDR, W_DATA} wsel_e;
  localparam int HB_WRITE  = 0;
  localparam int HB_BURST  = 1;
  localparam int HB_STREAM = 2;
endpackage

// File: rtl/lnk_edge_sync.sv
// Serial-domain synchronisers: core-edge alignment and the single wait sync point.
module lnk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ser,
  input  logic rst_n,
  input  logic core_tgl,
  input  logic wait_async,
  output logic load_now,
  output logic wait_s
);
  logic [1:0]             tgl_q;
  logic [SYNC_STAGES-1:0] wait_q;

  always_ff @(posedge clk_ser or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q  <= '0;
      wait_q <= '0;
    end else begin
      tgl_q  <= {tgl_q[0], core_tgl};
      wait_q <= {wait_q[SYNC_STAGES-2:0], wait_async};
    end
  end

  // A toggle from the core domain marks one load slot per core cycle,
  // placed mid-way through the core period where core registers are stable.
  assign load_now = tgl_q[1] ^ tgl_q[0];
  assign wait_s   = wait_q[SYNC_STAGES-1];
endmodule

// File: rtl/lnk_tx_shifter.sv
// Plain 4:1 parallel-to-serial stage; the only decision is stall on wait.
module lnk_tx_shifter #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk_ser,
  input  logic                    rst_n,
  input  logic                    load_now,
  input  logic                    wait_s,
  input  logic [BYTE_W*LANES-1:0] word_in,
  input  logic                    frame_in,
  output logic [BYTE_W-1:0]       ser_data,
  output logic                    ser_frame,
  output logic                    took,
  output logic                    halt
);
  localparam int WORD_W = BYTE_W * LANES;

  logic [WORD_W-1:0] sh_q;
  logic              frm_q;

  always_ff @(posedge clk_ser or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      frm_q <= 1'b0;
      took  <= 1'b0;
      halt  <= 1'b0;
    end else if (load_now) begin
      if (wait_s) begin
        sh_q  <= '0;
        frm_q <= 1'b0;
        took  <= 1'b0;
        halt  <= 1'b1;
      end else begin
        sh_q  <= word_in;
        frm_q <= frame_in;
        took  <= 1'b1;
        halt  <= 1'b0;
      end
    end else begin
      sh_q <= sh_q << BYTE_W;
    end
  end

  assign ser_data  = sh_q[WORD_W-1 -: BYTE_W];
  assign ser_frame = frm_q;
endmodule

// File: rtl/lnk_tx_formatter.sv
// Core-domain packet formatter: picks the word for each core cycle.
module lnk_tx_formatter
  import lnk_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int LANES     = 4,
  parameter int CTRL_W    = 8,
  parameter int ADDR_STEP = 8,
  parameter int CNT_W     = 16
) (
  input  logic                    clk_core,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W*LANES-1:0] in_addr,
  input  logic [BYTE_W*LANES-1:0] in_data,
  input  logic [CTRL_W-1:0]       in_ctrl,
  input  logic                    in_write,
  input  logic                    in_burst,
  input  logic                    in_stream,
  input  logic                    took,
  input  logic                    halt,
  output logic [BYTE_W*LANES-1:0] word_out,
  output logic                    frame_out,
  output logic                    done,
  output logic [CNT_W-1:0]        pkt_count,
  output logic                    core_tgl
);
  localparam int WORD_W = BYTE_W * LANES;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(ADDR_STEP);

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
    logic [CTRL_W-1:0] ctrl;
    logic              wr;
    logic              brq;
    logic              strm;
  } txn_t;

  function automatic logic is_burst(input txn_t t);
    return t.wr & t.brq;
  endfunction

  function automatic logic [WORD_W-1:0] head_word(input txn_t t);
    logic [WORD_W-1:0] w;
    logic [BYTE_W-1:0] h;
    h            = '0;
    h[HB_WRITE]  = t.wr;
    h[HB_BURST]  = is_burst(t);
    h[HB_STREAM] = is_burst(t) & t.strm;
    w            = '0;
    w[WORD_W-1 -: BYTE_W]        = h;
    w[WORD_W-BYTE_W-1 -: CTRL_W] = t.ctrl;
    return w;
  endfunction

  function automatic logic follows(input txn_t a, input txn_t p);
    logic [WORD_W-1:0] want;
    want = a.strm ? a.addr : a.addr + STEP;
    return is_burst(a) & is_burst(p) & (p.strm == a.strm) &
           (p.ctrl == a.ctrl) & (p.addr == want);
  endfunction

  txn_t              pend_q, act_q, act_n, in_txn;
  logic              pend_v;
  wsel_e             sel_q, sel_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              frm_q, frm_n;
  logic              done_q, done_n;
  logic              take_pend, cnt_inc;
  logic [CNT_W-1:0]  cnt_q;
  logic              tgl_q;

  assign in_txn = '{addr: in_addr, data: in_data, ctrl: in_ctrl,
                    wr: in_write, brq: in_burst, strm: in_stream};

  always_comb begin
    sel_n     = sel_q;
    word_n    = word_q;
    frm_n     = frm_q;
    act_n     = act_q;
    take_pend = 1'b0;
    cnt_inc   = 1'b0;
    if (!took) begin
      // Word was stalled: any packet in flight restarts from its header.
      if (sel_q != W_IDLE) begin
        sel_n  = W_HEAD;
        word_n = head_word(act_q);
        frm_n  = 1'b1;
      end
    end else begin
      unique case (sel_q)
        W_IDLE: begin
          if (pend_v) begin
            take_pend = 1'b1;
            act_n     = pend_q;
            sel_n     = W_HEAD;
            word_n    = head_word(pend_q);
            frm_n     = 1'b1;
          end
        end
        W_HEAD: begin
          sel_n  = W_ADDR;
          word_n = act_q.addr;
        end
        W_ADDR: begin
          sel_n  = W_DATA;
          word_n = act_q.data;
        end
        W_DATA: begin
          cnt_inc = 1'b1;
          if (pend_v && follows(act_q, pend_q)) begin
            take_pend = 1'b1;
            act_n     = pend_q;
            word_n    = pend_q.data;
          end else begin
            sel_n  = W_IDLE;
            word_n = '0;
            frm_n  = 1'b0;
          end
        end
        default: begin
          sel_n  = W_IDLE;
          word_n = '0;
          frm_n  = 1'b0;
        end
      endcase
    end
    if (sel_n == W_IDLE)    done_n = 1'b1;
    else if (is_burst(act_n)) done_n = 1'b0;
    else                    done_n = done_q;
  end

  assign in_ready = !halt && (!pend_v || take_pend);

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pend_v <= 1'b0;
      act_q  <= '0;
      sel_q  <= W_IDLE;
      word_q <= '0;
      frm_q  <= 1'b0;
      done_q <= 1'b1;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        pend_q <= in_txn;
        pend_v <= 1'b1;
      end else if (take_pend) begin
        pend_v <= 1'b0;
      end
      act_q  <= act_n;
      sel_q  <= sel_n;
      word_q <= word_n;
      frm_q  <= frm_n;
      done_q <= done_n;
      cnt_q  <= cnt_q + CNT_W'(cnt_inc);
      tgl_q  <= ~tgl_q;
    end
  end

  assign word_out  = word_q;
  assign frame_out = frm_q;
  assign done      = done_q;
  assign pkt_count = cnt_q;
  assign core_tgl  = tgl_q;
endmodule

// File: rtl/lnk_tx.sv
module lnk_tx #(
  parameter int BYTE_W      = 8,
  parameter int LANES       = 4,
  parameter int CTRL_W      = 8,
  parameter int ADDR_STEP   = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_ser,
  input  logic                    clk_core,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W*LANES-1:0] in_addr,
  input  logic [BYTE_W*LANES-1:0] in_data,
  input  logic [CTRL_W-1:0]       in_ctrl,
  input  logic                    in_write,
  input  logic                    in_burst,
  input  logic                    in_stream,
  input  logic                    link_wait,
  output logic [BYTE_W-1:0]       ser_data,
  output logic                    ser_frame,
  output logic                    done,
  output logic [CNT_W-1:0]        pkt_count
);
  localparam int WORD_W = BYTE_W * LANES;

  logic              load_now, wait_s, took, halt, core_tgl, frame_word;
  logic [WORD_W-1:0] word;

  lnk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_ser(clk_ser), .rst_n(rst_n), .core_tgl(core_tgl),
    .wait_async(link_wait), .load_now(load_now), .wait_s(wait_s)
  );

  lnk_tx_formatter #(
    .BYTE_W(BYTE_W), .LANES(LANES), .CTRL_W(CTRL_W),
    .ADDR_STEP(ADDR_STEP), .CNT_W(CNT_W)
  ) u_fmt (
    .clk_core(clk_core), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_ctrl(in_ctrl),
    .in_write(in_write), .in_burst(in_burst), .in_stream(in_stream),
    .took(took), .halt(halt),
    .word_out(word), .frame_out(frame_word),
    .done(done), .pkt_count(pkt_count), .core_tgl(core_tgl)
  );

  lnk_tx_shifter #(.BYTE_W(BYTE_W), .LANES(LANES)) u_shift (
    .clk_ser(clk_ser), .rst_n(rst_n), .load_now(load_now), .wait_s(wait_s),
    .word_in(word), .frame_in(frame_word),
    .ser_data(ser_data), .ser_frame(ser_frame), .took(took), .halt(halt)
  );
endmodule

// File: rtl/lnk_tx_chk.sv
module lnk_tx_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk_ser,
  input logic              clk_core,
  input logic              rst_n,
  input logic [BYTE_W-1:0] ser_data,
  input logic              ser_frame,
  input logic              load_now,
  input logic              wait_s,
  input logic              halt,
  input logic              in_ready,
  input logic              done,
  input logic              frame_word,
  input logic [CNT_W-1:0]  pkt_count
);
  p_idle_quiet_r1: assert property (@(posedge clk_ser) disable iff (!rst_n)
    !ser_frame |-> ser_data == '0);

  p_frame_on_boundary_r11: assert property (@(posedge clk_ser) disable iff (!rst_n)
    !load_now |=> $stable(ser_frame));

  p_wait_halts_r7: assert property (@(posedge clk_ser) disable iff (!rst_n)
    (load_now && wait_s) |=> !ser_frame);

  p_stall_blocks_ready_r3: assert property (@(posedge clk_core) disable iff (!rst_n)
    halt |-> !in_ready);

  p_count_step_r10: assert property (@(posedge clk_core) disable iff (!rst_n)
    (pkt_count != $past(pkt_count)) |-> (pkt_count == CNT_W'($past(pkt_count) + 1'b1)));

  p_done_when_idle_r9: assert property (@(posedge clk_core) disable iff (!rst_n)
    $rose(done) |-> !frame_word);
endmodule

bind lnk_tx lnk_tx_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk_ser(clk_ser), .clk_core(clk_core), .rst_n(rst_n),
  .ser_data(ser_data), .ser_frame(ser_frame), .load_now(load_now),
  .wait_s(wait_s), .halt(halt), .in_ready(in_ready), .done(done),
  .frame_word(frame_word), .pkt_count(pkt_count)
);

// File: tb/lnk_tx_test.sv
module lnk_tx_test;
  localparam int CLK_PERIOD = 4;
  localparam int CNT_W      = 5;

  logic       clk_ser = 1'b0;
  logic [1:0] div = '0;
  logic       clk_core;
  logic       rst_n = 1'b0;

  always #(CLK_PERIOD/2) clk_ser = ~clk_ser;
  always @(posedge clk_ser) div <= div + 2'd1;
  assign clk_core = div[1];

  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_addr = '0, in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_write = 1'b0, in_burst = 1'b0, in_stream = 1'b0;
  logic        link_wait = 1'b0;
  logic [7:0]  ser_data;
  logic        ser_frame, done;
  logic [CNT_W-1:0] pkt_count;

  lnk_tx #(.CNT_W(CNT_W)) uut (
    .clk_ser(clk_ser), .clk_core(clk_core), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_write(in_write),
    .in_burst(in_burst), .in_stream(in_stream), .link_wait(link_wait),
    .ser_data(ser_data), .ser_frame(ser_frame), .done(done),
    .pkt_count(pkt_count)
  );

  int n_chk = 0, n_fail = 0, sent_total = 0;
  bit ended = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ready as seen just before each core rising edge
  logic rdy_snap = 1'b0;
  always @(negedge clk_ser) if (div == 2'd1) rdy_snap = in_ready;

  bit saw_done_low = 0;
  always @(negedge clk_core) if (rst_n && !done) saw_done_low = 1;

  // expected transactions
  logic [31:0] e_addr [0:255];
  logic [31:0] e_data [0:255];
  logic [8:0]  e_cw   [0:255];
  int en = 0;

  // decoded from the line
  logic [7:0]  rb     [0:1023];
  logic [31:0] g_addr [0:255];
  logic [31:0] g_data [0:255];
  logic [8:0]  g_cw   [0:255];
  logic [7:0]  g_hdr  [0:255];
  int gn = 0, rlen = 0, runs = 0, aborted = 0, misalign = 0, malformed = 0;
  int gap = 0, min_gap = 1000;
  bit had_run = 0;

  function automatic logic [31:0] getw(input int k);
    return {rb[4*k], rb[4*k+1], rb[4*k+2], rb[4*k+3]};
  endfunction

  task automatic push_got(input logic [31:0] a, input logic [31:0] d, input logic [8:0] cw);
    if (gn < 256) begin g_addr[gn] = a; g_data[gn] = d; g_cw[gn] = cw; end
    gn++;
  endtask

  task automatic decode_run();
    int nw;
    logic [7:0]  hdr;
    logic [31:0] a;
    nw = rlen / 4;
    if (rlen % 4 != 0) misalign++;
    if (nw < 3) aborted++;
    else begin
      hdr = rb[0];
      if (runs < 256) g_hdr[runs] = hdr;
      runs++;
      a = getw(1);
      push_got(a, getw(2), {hdr[0], rb[1]});
      for (int k = 3; k < nw; k++) begin
        if (!hdr[1]) malformed++;
        if (!hdr[2]) a = a + 32'd8;
        push_got(a, getw(k), {hdr[0], rb[1]});
      end
    end
  endtask

  always @(negedge clk_ser) begin
    if (rst_n) begin
      if (ser_frame) begin
        if (rlen == 0 && had_run && gap < min_gap) min_gap = gap;
        if (rlen < 1024) rb[rlen] = ser_data;
        rlen++;
      end else begin
        if (rlen > 0) begin decode_run(); rlen = 0; gap = 0; had_run = 1; end
        gap++;
      end
    end
  end

  task automatic sync_core();
    @(posedge clk_core); #1;
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [7:0] c,
                      input logic wr, input logic br, input logic st);
    bit acc = 0;
    in_addr = a; in_data = d; in_ctrl = c; in_write = wr; in_burst = br; in_stream = st;
    in_valid = 1'b1;
    while (!acc) begin @(posedge clk_core); acc = rdy_snap; end
    #1 in_valid = 1'b0;
    e_addr[en] = a; e_data[en] = d; e_cw[en] = {wr, c};
    en++; sent_total++;
  endtask

  task automatic settle();
    repeat (40) @(posedge clk_core);
    #1;
  endtask

  task automatic check_delivery(input string tag, input int e0, input int g0);
    chk({tag, " delivered count"}, gn - g0, en - e0);
    for (int i = 0; i < en - e0 && i < gn - g0; i++) begin
      chk({tag, " addr/data"}, {g_addr[g0+i], g_data[g0+i]}, {e_addr[e0+i], e_data[e0+i]});
      chk({tag, " write/ctrl"}, 64'(g_cw[g0+i]), 64'(e_cw[e0+i]));
    end
  endtask

  task automatic check_count();
    chk("R10 packet counter", 64'(pkt_count), 64'(sent_total % (1 << CNT_W)));
  endtask

  task automatic t_reset();
    @(negedge clk_ser);
    chk("R1 frame after reset", ser_frame, 0);
    chk("R1 data after reset", ser_data, 0);
    chk("R1 done after reset", done, 1);
    chk("R1 counter after reset", pkt_count, 0);
  endtask

  task automatic t_single();
    int e0 = en, g0 = gn, r0 = runs;
    sync_core();
    send(32'h0000_1000, 32'hCAFE_0001, 8'h5A, 1'b1, 1'b0, 1'b0);
    send(32'h0000_2000, 32'hBEEF_0002, 8'hA5, 1'b0, 1'b1, 1'b1);
    settle();
    chk("R2 separate packets", runs - r0, 2);
    chk("R2 write header byte", g_hdr[r0], 8'h01);
    chk("R12 read header ignores burst/stream", g_hdr[r0+1], 8'h00);
    check_delivery("R2 R3 single", e0, g0);
    check_count();
  endtask

  task automatic t_burst_inc();
    int e0 = en, g0 = gn, r0 = runs;
    saw_done_low = 0;
    sync_core();
    for (int i = 0; i < 6; i++) send(32'h0000_3000 + 32'(i*8), 32'h1111_0000 + 32'(i), 8'h21, 1'b1, 1'b1, 1'b0);
    settle();
    chk("R4 one frame run for burst", runs - r0, 1);
    chk("R4 burst header byte", g_hdr[r0], 8'h03);
    check_delivery("R4 incrementing burst", e0, g0);
    chk("R9 done low during burst", saw_done_low, 1);
    chk("R9 done high when idle", done, 1);
    check_count();
  endtask

  task automatic t_burst_stream();
    int e0 = en, g0 = gn, r0 = runs;
    sync_core();
    for (int i = 0; i < 4; i++) send(32'h0000_5000, 32'h2222_0000 + 32'(i), 8'h07, 1'b1, 1'b1, 1'b1);
    settle();
    chk("R5 one frame run for stream", runs - r0, 1);
    chk("R5 stream header byte", g_hdr[r0], 8'h07);
    check_delivery("R5 stream burst", e0, g0);
  endtask

  task automatic t_burst_break();
    int e0 = en, g0 = gn, r0 = runs;
    sync_core();
    send(32'h0000_6000, 32'h3333_0000, 8'h10, 1'b1, 1'b1, 1'b0);
    send(32'h0000_6008, 32'h3333_0001, 8'h10, 1'b1, 1'b1, 1'b0);
    send(32'h0000_6018, 32'h3333_0002, 8'h10, 1'b1, 1'b1, 1'b0);
    send(32'h0000_6020, 32'h3333_0003, 8'h10, 1'b1, 1'b1, 1'b0);
    settle();
    chk("R6 address skip starts new header", runs - r0, 2);
    check_delivery("R6 broken burst", e0, g0);
    check_count();
  endtask

  task automatic t_wait();
    int e0 = en, g0 = gn;
    int lat = 0;
    bit high_seen = 0, rdy_low = 0;
    sync_core();
    fork
      begin
        for (int i = 0; i < 8; i++)
          send(32'h0000_4000 + 32'(i*8), 32'hD00D_0000 + 32'(i), 8'h33, 1'b1, 1'b1, 1'b0);
      end
      begin
        wait (ser_frame);
        repeat (10) @(negedge clk_ser);
        link_wait = 1'b1;
        while (ser_frame && lat < 20) begin @(negedge clk_ser); lat++; end
        chk("R7 frame drops within 6 serial cycles", lat <= 6, 1);
        repeat (80) begin
          @(negedge clk_ser);
          if (ser_frame) high_seen = 1;
          if (div == 2'd1 && !in_ready) rdy_low = 1;
        end
        chk("R7 frame held low during wait", high_seen, 0);
        chk("R3 ready low while stalled", rdy_low, 1);
        link_wait = 1'b0;
      end
    join
    settle();
    check_delivery("R8 stall no loss or repeat", e0, g0);
    check_count();
  endtask

  task automatic t_wrap();
    int e0 = en, g0 = gn, r0 = runs;
    sync_core();
    for (int i = 0; i < 40; i++) send(32'h0000_8000 + 32'(i*8), 32'h4444_0000 + 32'(i), 8'h44, 1'b1, 1'b1, 1'b0);
    settle();
    chk("R4 long burst stays in one frame", runs - r0, 1);
    check_delivery("R10 long burst", e0, g0);
    check_count();
  endtask

  initial begin
    repeat (5) @(negedge clk_ser);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_ser);
    t_reset();
    t_single();
    t_burst_inc();
    t_burst_stream();
    t_burst_break();
    t_wait();
    t_wrap();
    chk("R11 frame runs are whole words", misalign, 0);
    chk("R4 continuation only after burst header", malformed, 0);
    chk("R2 gap between packets at least 4", min_gap >= 4, 1);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_ser);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule